// File: doc/BRIEF.md
# Word-Programmable Non-Volatile Array Controller

This block sits between a simple register bus and an on-chip array of 32-bit non-volatile words. The array is modelled as a register file. Five control registers set the programming mode, the divider that produces the slow programming tick from the system clock, and the array power state. They also hold and clear the status flags. A separate memory window gives aligned word reads and writes into the array.

A single word written through the window while single-word mode is on starts a program cycle. The cycle lasts a fixed number of divider ticks. When it ends, the word is committed to the array, the `busy` output drops and a sticky end-of-program flag is raised. That flag drives `progIrq` until software clears it.

The array must be powered up before any access is valid. Each power-up is followed by a wake-up delay, also counted in divider ticks. A window access is refused with a sticky error flag when the array is:
- asleep or still waking,
- busy programming,
- in the wrong mode,
- targeted at a misaligned address,
- or, for writes, targeted at the protected last page.

Top module: `nvm_word_ctrl`

## Requirements
- R1: After reset the mode register reads 0, the divider reads 0, power-down reads 1 (array off), status reads 0, and `busy` and `progIrq` are low. Array contents are not cleared by reset.
- R2: Register offsets are decoded on `regAddr`, with read data on `regRdata` one cycle after `regRead` is sampled:
  - mode at 0x00C, bit 0;
  - divider at 0x014, bits DIV_W-1:0;
  - power-down at 0x018, bit 0;
  - status at 0xFE0, bit 2 end-of-program and bit 0 error.
  The clear register at 0xFE8 and unmapped offsets read 0.
- R3: Writing 0 to power-down while it reads 1 starts the wake-up delay. Window accesses sampled up to and including WAKE_TICKS*(div+1) clock edges after that write are rejected. Accesses from the next edge on are accepted.
- R4: A window write is accepted when all of the following hold: mode bit is 1, the array is awake, it is idle, the byte address is aligned, and the word lies outside the last page. `busy` rises on the sampling edge and stays high for exactly PROG_TICKS*(div+1) cycles. On the edge where it falls, the end-of-program flag sets, `progIrq` goes high and the word becomes readable.
- R5: A window read that is aligned, awake and idle returns the stored word on `memRdata` one cycle later. Any other read returns 0 and sets the error flag.
- R6: A write to any word of the last PAGE_BYTES-byte page never starts a cycle and sets the error flag.
- R7: A window write is ignored and sets the error flag in any of these cases: during a program cycle, while powered down, while waking, with mode bit 0, or with `memAddr[1:0]` not 00. The stored contents do not change.
- R8: Both status flags are sticky. Writing 1 to bit 2 of 0xFE8 clears end-of-program, and writing 1 to bit 0 clears error. A clear bit written as 0 leaves its flag unchanged.
- R9: A power-down register write during a program cycle is ignored; power-down keeps reading 0.
- R10: Words written before a reset are read back unchanged after reset and a fresh power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Register byte offset |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, one cycle after `regRead` |
| memAddr | input | ADDR_W | Memory window byte address |
| memWrite | input | 1 | Memory window write strobe |
| memRead | input | 1 | Memory window read strobe |
| memWdata | input | 32 | Word to program |
| memRdata | output | 32 | Word read back, one cycle after `memRead` |
| busy | output | 1 | High while a program cycle runs |
| progIrq | output | 1 | Level of the end-of-program flag |

## Verification
Register and window reads are sampled on one rising edge, and their data is due on the following edge. The bench drives every request on a falling edge and reads results on the next falling edge, half a cycle after the data edge.

For programming, `busy` is due on the edge that accepts the write. It must still be high after PROG_TICKS*(div+1)-1 further edges and low, with `progIrq` set, one edge later. The bench counts exactly those edges for several divider values.

The wake-up window is probed twice: once with an access exactly on the last rejected edge, and once one edge later.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [11:0] OFS_MODE = 12'h00C;
  localparam logic [11:0] OFS_DIV  = 12'h014;
  localparam logic [11:0] OFS_PWR  = 12'h018;
  localparam logic [11:0] OFS_STAT = 12'hFE0;
  localparam logic [11:0] OFS_CLR  = 12'hFE8;

  localparam int BIT_EOP = 2;
  localparam int BIT_ERR = 0;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAKE,
    ST_READY,
    ST_PROG
  } nvmState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch word and index of an accepted write
    logic commit;      // program the latched word into the array
    logic readServe;   // return the addressed word
    logic readReject;  // return zero
  } dpStrobe_t;
endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int ARRAY_BYTES = 1024,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_TICKS  = 4500,
  parameter int WAKE_TICKS  = 150,
  localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWrite,
  input  logic              memRead,
  output dpStrobe_t         strb,
  output logic              busy,
  output logic              progIrq
);
  localparam int WIDX_W     = ADDR_W - 2;
  localparam int WORDS      = ARRAY_BYTES / 4;
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam int LOCK_BASE  = WORDS - PAGE_WORDS;
  localparam int MAX_TICKS  = (PROG_TICKS > WAKE_TICKS) ? PROG_TICKS : WAKE_TICKS;
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);
  localparam logic [WIDX_W-1:0] LOCK_IDX  = WIDX_W'(LOCK_BASE);
  localparam logic [CNT_W-1:0]  ONE_LEFT  = CNT_W'(1);

  nvmState_t         state;
  logic [CNT_W-1:0]  tickLeft;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divReg;
  logic              modeReg;
  logic              pwrReg;
  logic              eopFlag;
  logic              errFlag;

  logic wrMode, wrDiv, wrPwr, wrClr;
  logic tick, aligned, lockedHit;
  logic wrOk, rdOk, pwrAccept, pwrUp, pwrDown, progEnd;
  logic clrEop, clrErr, setErr;

  always_comb begin
    wrMode    = regWrite && (regAddr == OFS_MODE);
    wrDiv     = regWrite && (regAddr == OFS_DIV);
    wrPwr     = regWrite && (regAddr == OFS_PWR);
    wrClr     = regWrite && (regAddr == OFS_CLR);
    tick      = (divCnt >= divReg);
    aligned   = (memAddr[1:0] == 2'b00);
    lockedHit = (memAddr[ADDR_W-1:2] >= LOCK_IDX);
    wrOk      = memWrite && (state == ST_READY) && modeReg && aligned && !lockedHit;
    rdOk      = memRead && (state == ST_READY) && aligned;
    pwrAccept = wrPwr && (state != ST_PROG) && !wrOk;
    pwrUp     = pwrAccept && !regWdata[0] && pwrReg;
    pwrDown   = pwrAccept && regWdata[0];
    progEnd   = (state == ST_PROG) && tick && (tickLeft == ONE_LEFT);
    clrEop    = wrClr && regWdata[BIT_EOP];
    clrErr    = wrClr && regWdata[BIT_ERR];
    setErr    = (memWrite && !wrOk) || (memRead && !rdOk);
    strb.capture    = wrOk;
    strb.commit     = progEnd;
    strb.readServe  = rdOk;
    strb.readReject = memRead && !rdOk;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= 1'b0;
      divReg  <= '0;
      pwrReg  <= 1'b1;
    end else begin
      if (wrMode)    modeReg <= regWdata[0];
      if (wrDiv)     divReg  <= regWdata[DIV_W-1:0];
      if (pwrAccept) pwrReg  <= regWdata[0];
    end
  end

  // tick divider, restarted whenever a timed phase begins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     divCnt <= '0;
    else if (wrOk || pwrUp || tick) divCnt <= '0;
    else                           divCnt <= divCnt + 1'b1;
  end

  // power / program sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      tickLeft <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          if (pwrUp) begin
            state    <= ST_WAKE;
            tickLeft <= CNT_W'(WAKE_TICKS);
          end
        end
        ST_WAKE: begin
          if (pwrDown) state <= ST_OFF;
          else if (tick) begin
            if (tickLeft == ONE_LEFT) state <= ST_READY;
            tickLeft <= tickLeft - 1'b1;
          end
        end
        ST_READY: begin
          if (wrOk) begin
            state    <= ST_PROG;
            tickLeft <= CNT_W'(PROG_TICKS);
          end else if (pwrDown) begin
            state <= ST_OFF;
          end
        end
        default: begin
          if (tick) begin
            if (tickLeft == ONE_LEFT) state <= ST_READY;
            tickLeft <= tickLeft - 1'b1;
          end
        end
      endcase
    end
  end

  // sticky status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eopFlag <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (progEnd)     eopFlag <= 1'b1;
      else if (clrEop) eopFlag <= 1'b0;
      if (setErr)      errFlag <= 1'b1;
      else if (clrErr) errFlag <= 1'b0;
    end
  end

  // register read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdata <= '0;
    else if (regRead) begin
      case (regAddr)
        OFS_MODE: regRdata <= {31'b0, modeReg};
        OFS_DIV:  regRdata <= 32'(divReg);
        OFS_PWR:  regRdata <= {31'b0, pwrReg};
        OFS_STAT: regRdata <= {29'b0, eopFlag, 1'b0, errFlag};
        default:  regRdata <= '0;
      endcase
    end
  end

  assign busy    = (state == ST_PROG);
  assign progIrq = eopFlag;

  assert_busy_end_sets_eop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> eopFlag);

  assert_eop_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eopFlag && !clrEop) |=> eopFlag);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrErr) |=> errFlag);

  assert_pwr_hold_in_prog_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(pwrReg));

  assert_off_when_powered_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    pwrReg |-> (state == ST_OFF));
endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int PAGE_BYTES  = 128,
  localparam int ADDR_W     = $clog2(ARRAY_BYTES),
  localparam int WIDX_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [31:0]       memWdata,
  output logic [31:0]       memRdata
);
  localparam int WORDS      = ARRAY_BYTES / 4;
  localparam int PAGE_WORDS = PAGE_BYTES / 4;
  localparam logic [WIDX_W-1:0] LOCK_IDX = WIDX_W'(WORDS - PAGE_WORDS);

  logic [31:0]       cells [WORDS];
  logic [WIDX_W-1:0] pendIdx;
  logic [31:0]       pendData;

  // array content survives reset
  always_ff @(posedge clk) begin
    if (strb.commit) cells[pendIdx] <= pendData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIdx  <= '0;
      pendData <= '0;
      memRdata <= '0;
    end else begin
      if (strb.capture) begin
        pendIdx  <= wordIdx;
        pendData <= memWdata;
      end
      if (strb.readServe)       memRdata <= cells[wordIdx];
      else if (strb.readReject) memRdata <= '0;
    end
  end

  assert_no_locked_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (pendIdx < LOCK_IDX));

  assert_reject_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.readReject |=> (memRdata == 32'h0));
endmodule

// File: rtl/nvm_word_ctrl.sv
module nvm_word_ctrl
  import nvm_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int ARRAY_BYTES = 1024,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_TICKS  = 4500,
  parameter int WAKE_TICKS  = 150,
  localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWrite,
  input  logic              memRead,
  input  logic [31:0]       memWdata,
  output logic [31:0]       memRdata,
  output logic              busy,
  output logic              progIrq
);
  dpStrobe_t strb;

  nvm_ctrl #(
    .DIV_W(DIV_W), .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .PROG_TICKS(PROG_TICKS), .WAKE_TICKS(WAKE_TICKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrite(regWrite), .regRead(regRead),
    .regWdata(regWdata), .regRdata(regRdata),
    .memAddr(memAddr), .memWrite(memWrite), .memRead(memRead),
    .strb(strb), .busy(busy), .progIrq(progIrq)
  );

  nvm_datapath #(
    .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wordIdx(memAddr[ADDR_W-1:2]),
    .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: tb/tb_nvm_word_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_word_ctrl;
  localparam int P = 4;
  localparam int W = 3;
  localparam logic [11:0] A_MODE = 12'h00C, A_DIV = 12'h014, A_PWR = 12'h018,
                          A_STAT = 12'hFE0, A_CLR = 12'hFE8;

  typedef struct packed {
    logic [9:0]  addr;
    logic [31:0] data;
    logic [15:0] div;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{addr: 10'h000, data: 32'hA5A5_0001, div: 16'd0},
    '{addr: 10'h004, data: 32'h1234_5678, div: 16'd1},
    '{addr: 10'h1F0, data: 32'hDEAD_BEEF, div: 16'd2},
    '{addr: 10'h37C, data: 32'h0F0F_F0F0, div: 16'd0},
    '{addr: 10'h200, data: 32'hFFFF_FFFF, div: 16'd3},
    '{addr: 10'h008, data: 32'h8000_0001, div: 16'd1}
  };

  logic clk = 0, rstN = 0;
  logic [11:0] regAddr = '0;
  logic regWrite = 0, regRead = 0;
  logic [31:0] regWdata = '0, regRdata;
  logic [9:0] memAddr = '0;
  logic memWrite = 0, memRead = 0;
  logic [31:0] memWdata = '0, memRdata;
  logic busy, progIrq;
  int total = 0, bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  nvm_word_ctrl #(.DIV_W(16), .ARRAY_BYTES(1024), .PAGE_BYTES(128),
                  .PROG_TICKS(P), .WAKE_TICKS(W)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regRead(regRead), .regWdata(regWdata), .regRdata(regRdata),
    .memAddr(memAddr), .memWrite(memWrite), .memRead(memRead),
    .memWdata(memWdata), .memRdata(memRdata), .busy(busy), .progIrq(progIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic regWr(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrite = 1;
    @(posedge clk); @(negedge clk); regWrite = 0;
  endtask
  task automatic regRd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a; regRead = 1;
    @(posedge clk); @(negedge clk); regRead = 0; d = regRdata;
  endtask
  task automatic memWr(input logic [9:0] a, input logic [31:0] d);
    memAddr = a; memWdata = d; memWrite = 1;
    @(posedge clk); @(negedge clk); memWrite = 0;
  endtask
  task automatic memRd(input logic [9:0] a, output logic [31:0] d);
    memAddr = a; memRead = 1;
    @(posedge clk); @(negedge clk); memRead = 0; d = memRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 irq", 32'(progIrq), 0);
    regRd(A_MODE, rv); check("R1 mode", rv, 0);
    regRd(A_DIV, rv);  check("R1 div", rv, 0);
    regRd(A_PWR, rv);  check("R1 pwr", rv, 1);
    regRd(A_STAT, rv); check("R1 status", rv, 0);

    // R7 write while powered down
    memWr(10'h010, 32'h1);
    check("R7 off no busy", 32'(busy), 0);
    regRd(A_STAT, rv); check("R7 off err", rv, 32'h1);
    regWr(A_CLR, 32'h1);
    regRd(A_STAT, rv); check("R8 err clear", rv, 0);

    // R3 wake window, divider 2
    regWr(A_DIV, 32'd2);
    regWr(A_PWR, 32'd0);
    cyc(W * 3 - 1);
    memRd(10'h000, rv); check("R3 last rejected edge data", rv, 0);
    regRd(A_STAT, rv);  check("R3 last rejected edge err", rv, 32'h1);
    regWr(A_PWR, 32'd1);
    regWr(A_CLR, 32'h1);
    regWr(A_PWR, 32'd0);
    cyc(W * 3);
    memRd(10'h000, rv);
    regRd(A_STAT, rv);  check("R3 first accepted edge", rv, 0);

    // R2 readback and decoding
    regRd(A_DIV, rv);    check("R2 div", rv, 2);
    regRd(A_PWR, rv);    check("R2 pwr", rv, 0);
    regRd(12'h010, rv);  check("R2 unmapped", rv, 0);
    regRd(A_CLR, rv);    check("R2 clr reads 0", rv, 0);

    // R7 mode off
    memWr(10'h010, 32'h55);
    check("R7 mode0 no busy", 32'(busy), 0);
    regRd(A_STAT, rv); check("R7 mode0 err", rv, 32'h1);
    regWr(A_CLR, 32'h1);
    regWr(A_MODE, 32'h1);
    regRd(A_MODE, rv); check("R2 mode", rv, 1);

    // R4 / R5 vector table
    for (int i = 0; i < 6; i++) begin
      int n;
      n = P * (int'(VECS[i].div) + 1);
      regWr(A_DIV, 32'(VECS[i].div));
      memWr(VECS[i].addr, VECS[i].data);
      check("R4 busy rise", 32'(busy), 1);
      cyc(n - 1);
      check("R4 busy held", 32'(busy), 1);
      cyc(1);
      check("R4 busy fall", 32'(busy), 0);
      check("R4 irq set", 32'(progIrq), 1);
      memRd(VECS[i].addr, rv); check("R5 readback", rv, VECS[i].data);
      regWr(A_CLR, 32'h4);
      check("R8 eop clear", 32'(progIrq), 0);
    end

    // busy corner cases, divider 1
    regWr(A_DIV, 32'd1);
    memWr(10'h000, 32'h1111_2222);
    memWr(10'h004, 32'hBAD0_BAD0);
    memRd(10'h000, rv); check("R5 read while busy", rv, 0);
    regWr(A_PWR, 32'd1);
    regRd(A_PWR, rv);   check("R9 pwr write in prog", rv, 0);
    for (int k = 0; k < 100 && busy; k++) cyc(1);
    regRd(A_STAT, rv);  check("R7 busy write err", rv, 32'h5);
    memRd(10'h004, rv); check("R7 busy write ignored", rv, 32'h1234_5678);
    memRd(10'h000, rv); check("R4 committed", rv, 32'h1111_2222);

    // R8 stickiness
    cyc(20);
    check("R8 irq holds", 32'(progIrq), 1);
    regWr(A_CLR, 32'h1);
    regRd(A_STAT, rv); check("R8 err-only clear", rv, 32'h4);
    regWr(A_CLR, 32'h4);
    regRd(A_STAT, rv); check("R8 eop cleared", rv, 0);

    // R6 protected last page
    memWr(10'h380, 32'h7777_7777);
    check("R6 first word no busy", 32'(busy), 0);
    memWr(10'h3FC, 32'h7777_7777);
    check("R6 last word no busy", 32'(busy), 0);
    check("R6 no irq", 32'(progIrq), 0);
    regRd(A_STAT, rv); check("R6 err", rv, 32'h1);
    regWr(A_CLR, 32'h1);

    // R7 misaligned
    memWr(10'h002, 32'h9999_9999);
    check("R7 misaligned no busy", 32'(busy), 0);
    memRd(10'h000, rv); check("R7 misaligned ignored", rv, 32'h1111_2222);
    memRd(10'h001, rv); check("R5 misaligned read", rv, 0);
    regRd(A_STAT, rv);  check("R7 misaligned err", rv, 32'h1);

    // R10 contents survive reset
    rstN = 0; cyc(2); rstN = 1;
    regRd(A_PWR, rv); check("R1 pwr after reset", rv, 1);
    regWr(A_PWR, 32'd0);
    cyc(W);
    memRd(10'h1F0, rv); check("R10 kept word", rv, 32'hDEAD_BEEF);
    memRd(10'h37C, rv); check("R10 kept top word", rv, 32'h0F0F_F0F0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule